// File: doc/BRIEF.md
# NAND Controller Command Buffer Front-End

This block is the host-facing register side of a NAND flash controller. A 32-bit memory-mapped slave port reaches a control register, a status register and a command buffer of three or four words. Software sets the run bit, waits for the command-request flag, and then writes every command word to the first command-word address. The block places the words in successive slots. When the last slot is filled it hands the whole command to a downstream pin sequencer with a one-cycle valid.

The sequencer and the ECC engine report back through single-cycle event pulses. The block collects these into sticky status bits that software clears by writing 1. Completion and page events go to the chip select that bit 24 of command word 0 named. A corrected-error count sits in its own status field. An interrupt output is raised when an unmasked status bit is set.

Top module: `nand_cmd_frontend`

## Requirements
- R1: After reset the control register, the status register and all command words read 0, `irq` is 0 and `cmd_valid` is 0.
- R2: The command-request flag (status bit 0) is set one cycle after the run bit (control bit 28) becomes 1. A write to the first command-word address (offset 0x48) while run is 0 is discarded, and `cmd_valid` never rises while run is 0.
- R3: While accepting, each write to offset 0x48 fills the next slot: word 0, 1, 2, and then word 3 if FOUR_WORDS=1. Word k reads back at offset 0x48+4k.
- R4: Writes to offsets 0x4C, 0x50 and 0x54 do not change any command word.
- R5: The cycle after the last word is written, `cmd_valid` is high for exactly one cycle and `cmd_words` holds the words in slot order (word k at bits 32k+31:32k). Status bit 0 is cleared at that write and stays 0 until `seq_done`. Command-word writes made while waiting for `seq_done` are discarded.
- R6: A `seq_done` pulse sets command-done bit 8 when word 0 bit 24 was 0, or bit 7 when it was 1. It also sets status bit 0 again.
- R7: Event pulses set status bits: page done 10 (CS0) / 9 (CS1), bad block 6 (CS0) / 5 (CS1), uncorrectable 4, corrected 3, write-data request 2, read-data request 1. While `flash_rdy0` is high, bit 11 is set. Bit 12 shows `flash_rdy1` delayed by one cycle and is not sticky.
- R8: Writing the status register (offset 0x14) clears each of bits 11:0 that has a 1 in the write data. An event that arrives in the same cycle leaves its bit set.
- R9: `ev_corr` loads `ev_corr_cnt` into status bits 20:16. A status write with bits 20:16 zero clears the field. A status write with a nonzero value there leaves it unchanged.
- R10: `irq` is the OR, one cycle later, of every status bit in 11:0 whose mask bit in control 11:0 is 0 (1 = masked).
- R11: Clearing the run bit abandons a partly written command: after run is set again, the next write to 0x48 fills word 0.
- R12: The control register (offset 0x00) reads back all 32 bits written. Reads return data one cycle after `bus_rd`, and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after `bus_rd` |
| irq | output | 1 | Interrupt, OR of unmasked status bits |
| cmd_valid | output | 1 | One-cycle strobe: full command available |
| cmd_words | output | 128 | Command words, word k at bits 32k+31:32k |
| seq_done | input | 1 | Pulse from the sequencer: command finished |
| ev_page_done | input | 1 | Pulse: page transfer finished |
| ev_bad_block | input | 1 | Pulse: bad-block marker detected |
| ev_uncorr | input | 1 | Pulse: uncorrectable ECC error |
| ev_corr | input | 1 | Pulse: corrected ECC error |
| ev_corr_cnt | input | 5 | Corrected-bit count, valid with `ev_corr` |
| ev_wr_req | input | 1 | Pulse: write-data request |
| ev_rd_req | input | 1 | Pulse: read-data request |
| flash_rdy0 | input | 1 | Ready level for the first chip select |
| flash_rdy1 | input | 1 | Ready level for the second chip select |

## Verification
The hardest case to reach from the ports is a command left half-written when run is dropped. The bench writes two words, clears and sets the run bit, and then loads a full command. The strobed words must show the new word 0, with nothing left over from the abandoned one. The bench also writes a command word while waiting for `seq_done`, and fires an event in the same cycle as a write-1-to-clear of that bit. Both show up only in later readback. After that, a seeded random mix of event pulses, clears and mask changes is compared with a status model kept in the bench.

// File: rtl/nfe_pkg.sv
package nfe_pkg;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned MAX_WORDS = 4;
  localparam int unsigned EVT_W     = 12;

  localparam logic [7:0] OFF_CTRL = 8'h00;
  localparam logic [7:0] OFF_STAT = 8'h14;
  localparam logic [7:0] OFF_CMD0 = 8'h48;

  localparam int unsigned RUN_BIT  = 28;
  localparam int unsigned CSEL_BIT = 24;
  localparam int unsigned CNT_LSB  = 16;
  localparam int unsigned CNT_W    = 5;

  typedef enum logic [1:0] {
    LD_STOP   = 2'd0,
    LD_ACCEPT = 2'd1,
    LD_BUSY   = 2'd2
  } ld_state_e;
endpackage

// File: rtl/nfe_cmd_loader.sv
module nfe_cmd_loader
  import nfe_pkg::*;
#(
  parameter int unsigned NWORDS = 4
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          run_i,
  input  logic                          wr_i,
  input  logic [DATA_W-1:0]             wdata_i,
  input  logic                          seq_done_i,
  output logic [MAX_WORDS*DATA_W-1:0]   words_o,
  output logic                          valid_o,
  output logic                          cs_o,
  output logic                          req_set_o,
  output logic                          req_clr_o,
  output logic                          done_set_o
);
  localparam int unsigned PTR_W = (NWORDS > 1) ? $clog2(NWORDS) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NWORDS - 1);

  ld_state_e        state_q;
  logic [PTR_W-1:0] ptr_q;
  logic             accept_wr;
  logic             last_wr;

  assign accept_wr  = run_i && (state_q == LD_ACCEPT) && wr_i;
  assign last_wr    = accept_wr && (ptr_q == LAST);
  assign req_clr_o  = last_wr;
  assign done_set_o = run_i && (state_q == LD_BUSY) && seq_done_i;
  assign req_set_o  = (run_i && (state_q == LD_STOP)) || done_set_o;

  always_ff @(posedge clk) begin
    if (rst || !run_i) begin
      state_q <= LD_STOP;
      ptr_q   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= last_wr;
      case (state_q)
        LD_STOP:   state_q <= LD_ACCEPT;
        LD_ACCEPT: if (accept_wr) begin
          if (last_wr) begin
            ptr_q   <= '0;
            state_q <= LD_BUSY;
          end else begin
            ptr_q <= ptr_q + 1'b1;
          end
        end
        LD_BUSY:   if (seq_done_i) state_q <= LD_ACCEPT;
        default:   state_q <= LD_STOP;
      endcase
    end
  end

  genvar g;
  generate
    for (g = 0; g < MAX_WORDS; g++) begin : g_slot
      if (g < NWORDS) begin : g_live
        logic [DATA_W-1:0] word_q;
        always_ff @(posedge clk) begin
          if (rst) word_q <= '0;
          else if (accept_wr && (ptr_q == PTR_W'(g))) word_q <= wdata_i;
        end
        assign words_o[g*DATA_W +: DATA_W] = word_q;
      end else begin : g_absent
        assign words_o[g*DATA_W +: DATA_W] = '0;
      end
    end
  endgenerate

  assign cs_o = words_o[CSEL_BIT];

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
    valid_o |=> !valid_o); // R5
  AST_STOP_NO_VALID: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> !valid_o); // R2
  AST_STOP_REWINDS: assert property (@(posedge clk) disable iff (rst)
    !run_i |=> (ptr_q == '0) && (state_q == LD_STOP)); // R11
endmodule

// File: rtl/nfe_status.sv
module nfe_status
  import nfe_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_i,
  input  logic [EVT_W-1:0] clr_mask_i,
  input  logic             cnt_zero_i,
  input  logic [EVT_W-1:0] irq_mask_i,
  input  logic             cs_i,
  input  logic             req_set_i,
  input  logic             req_clr_i,
  input  logic             done_set_i,
  input  logic             page_i,
  input  logic             bbd_i,
  input  logic             uncorr_i,
  input  logic             corr_i,
  input  logic [CNT_W-1:0] corr_cnt_i,
  input  logic             wreq_i,
  input  logic             rreq_i,
  input  logic             rdy0_i,
  input  logic             rdy1_i,
  output logic [DATA_W-1:0] stat_o,
  output logic             irq_o
);
  logic [EVT_W-1:0] bits_q, set_vec, clr_vec;
  logic [CNT_W-1:0] cnt_q;
  logic             rdy1_q;

  always_comb begin
    set_vec     = '0;
    set_vec[0]  = req_set_i;
    set_vec[1]  = rreq_i;
    set_vec[2]  = wreq_i;
    set_vec[3]  = corr_i;
    set_vec[4]  = uncorr_i;
    set_vec[5]  = bbd_i && cs_i;
    set_vec[6]  = bbd_i && !cs_i;
    set_vec[7]  = done_set_i && cs_i;
    set_vec[8]  = done_set_i && !cs_i;
    set_vec[9]  = page_i && cs_i;
    set_vec[10] = page_i && !cs_i;
    set_vec[11] = rdy0_i;
    clr_vec     = (wr_i ? clr_mask_i : '0) | {{(EVT_W-1){1'b0}}, req_clr_i};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bits_q <= '0;
      cnt_q  <= '0;
      rdy1_q <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      bits_q <= (bits_q & ~clr_vec) | set_vec;
      rdy1_q <= rdy1_i;
      irq_o  <= |(bits_q & ~irq_mask_i);
      if (corr_i) cnt_q <= corr_cnt_i;
      else if (wr_i && cnt_zero_i) cnt_q <= '0;
    end
  end

  assign stat_o = {{(DATA_W-CNT_LSB-CNT_W){1'b0}}, cnt_q, 3'b000, rdy1_q, bits_q};

  AST_SET_WINS: assert property (@(posedge clk) disable iff (rst)
    (|set_vec) |=> ((bits_q & $past(set_vec)) == $past(set_vec))); // R8
  AST_FULL_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (wr_i && (&clr_mask_i) && (set_vec == '0)) |=> (bits_q == '0)); // R8
  AST_CNT_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (wr_i && cnt_zero_i && !corr_i) |=> (cnt_q == '0)); // R9
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
    ((bits_q & ~irq_mask_i) == '0) |=> !irq_o); // R10
endmodule

// File: rtl/nand_cmd_frontend.sv
module nand_cmd_frontend
  import nfe_pkg::*;
#(
  parameter int unsigned ADDR_W     = 8,
  parameter bit          FOUR_WORDS = 1'b1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        bus_wr,
  input  logic                        bus_rd,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic [31:0]                 bus_wdata,
  output logic [31:0]                 bus_rdata,
  output logic                        irq,
  output logic                        cmd_valid,
  output logic [127:0]                cmd_words,
  input  logic                        seq_done,
  input  logic                        ev_page_done,
  input  logic                        ev_bad_block,
  input  logic                        ev_uncorr,
  input  logic                        ev_corr,
  input  logic [4:0]                  ev_corr_cnt,
  input  logic                        ev_wr_req,
  input  logic                        ev_rd_req,
  input  logic                        flash_rdy0,
  input  logic                        flash_rdy1
);
  localparam int unsigned NWORDS = FOUR_WORDS ? 4 : 3;

  logic [DATA_W-1:0] ctrl_q, stat_w, rdata_c;
  logic wr_ctrl, wr_stat, wr_cmd0;
  logic cs_w, req_set_w, req_clr_w, done_set_w;

  assign wr_ctrl = bus_wr && (bus_addr == ADDR_W'(OFF_CTRL));
  assign wr_stat = bus_wr && (bus_addr == ADDR_W'(OFF_STAT));
  assign wr_cmd0 = bus_wr && (bus_addr == ADDR_W'(OFF_CMD0));

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= '0;
    else if (wr_ctrl) ctrl_q <= bus_wdata;
  end

  nfe_cmd_loader #(.NWORDS(NWORDS)) loader_i (
    .clk(clk), .rst(rst), .run_i(ctrl_q[RUN_BIT]), .wr_i(wr_cmd0),
    .wdata_i(bus_wdata), .seq_done_i(seq_done), .words_o(cmd_words),
    .valid_o(cmd_valid), .cs_o(cs_w), .req_set_o(req_set_w),
    .req_clr_o(req_clr_w), .done_set_o(done_set_w)
  );

  nfe_status status_i (
    .clk(clk), .rst(rst), .wr_i(wr_stat), .clr_mask_i(bus_wdata[EVT_W-1:0]),
    .cnt_zero_i(bus_wdata[CNT_LSB +: CNT_W] == '0), .irq_mask_i(ctrl_q[EVT_W-1:0]),
    .cs_i(cs_w), .req_set_i(req_set_w), .req_clr_i(req_clr_w),
    .done_set_i(done_set_w), .page_i(ev_page_done), .bbd_i(ev_bad_block),
    .uncorr_i(ev_uncorr), .corr_i(ev_corr), .corr_cnt_i(ev_corr_cnt),
    .wreq_i(ev_wr_req), .rreq_i(ev_rd_req), .rdy0_i(flash_rdy0),
    .rdy1_i(flash_rdy1), .stat_o(stat_w), .irq_o(irq)
  );

  always_comb begin
    rdata_c = '0;
    if (bus_addr == ADDR_W'(OFF_CTRL)) rdata_c = ctrl_q;
    if (bus_addr == ADDR_W'(OFF_STAT)) rdata_c = stat_w;
    for (int k = 0; k < MAX_WORDS; k++)
      if (bus_addr == ADDR_W'(OFF_CMD0 + 4*k)) rdata_c = cmd_words[k*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rdata_c;
  end

  AST_REQ_LOW_ON_ISSUE: assert property (@(posedge clk) disable iff (rst)
    cmd_valid |-> !stat_w[0]); // R5
endmodule

// File: tb/nand_cmd_frontend_tb_top.sv
module nand_cmd_frontend_tb_top;
  localparam int PERIOD = 10;
  localparam logic [7:0] A_CTRL = 8'h00, A_STAT = 8'h14, A_C0 = 8'h48,
                         A_C1 = 8'h4C, A_C2 = 8'h50, A_C3 = 8'h54;
  localparam logic [31:0] RUN = 32'h1000_0000;

  logic clk = 0, rst = 1;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic irq, cmd_valid;
  logic [127:0] cmd_words;
  logic seq_done = 0, ev_page_done = 0, ev_bad_block = 0, ev_uncorr = 0, ev_corr = 0;
  logic [4:0] ev_corr_cnt = 0;
  logic ev_wr_req = 0, ev_rd_req = 0, flash_rdy0 = 0, flash_rdy1 = 0;

  int checks = 0, errors = 0, valid_cnt = 0;
  logic [127:0] cap_words;
  logic [11:0] m_bits;
  logic [4:0]  m_cnt;
  logic        m_cs;
  logic [31:0] rd;

  always #(PERIOD/2) clk = ~clk;

  nand_cmd_frontend dut_i (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .cmd_valid(cmd_valid),
    .cmd_words(cmd_words), .seq_done(seq_done), .ev_page_done(ev_page_done),
    .ev_bad_block(ev_bad_block), .ev_uncorr(ev_uncorr), .ev_corr(ev_corr),
    .ev_corr_cnt(ev_corr_cnt), .ev_wr_req(ev_wr_req), .ev_rd_req(ev_rd_req),
    .flash_rdy0(flash_rdy0), .flash_rdy1(flash_rdy1)
  );

  always @(negedge clk) if (cmd_valid) begin
    valid_cnt++;
    cap_words = cmd_words;
  end

  task automatic check(input logic [127:0] act, input logic [127:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rdreg(input logic [7:0] a, output logic [31:0] d);
    bus_rd = 1; bus_addr = a;
    @(negedge clk);
    bus_rd = 0;
    d = bus_rdata;
  endtask

  function automatic logic [11:0] ev_bits(input logic [5:0] r, input logic cs);
    logic [11:0] b = '0;
    b[4] = r[0]; b[3] = r[1]; b[2] = r[2]; b[1] = r[3];
    if (cs) begin b[9] = r[4]; b[5] = r[5]; end
    else    begin b[10] = r[4]; b[6] = r[5]; end
    return b;
  endfunction

  task automatic load4(input logic [31:0] w0, w1, w2, w3);
    wr(A_C0, w0); wr(A_C0, w1); wr(A_C0, w2); wr(A_C0, w3);
    idle(1);
  endtask

  task automatic done_pulse();
    seq_done = 1; @(negedge clk); seq_done = 0; idle(1);
  endtask

  initial begin
    #(PERIOD*100000);
    errors++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int v0;
    idle(3); rst = 0; idle(1);
    // R1 reset state
    rdreg(A_CTRL, rd); check(rd, 0, "R1 ctrl");
    rdreg(A_STAT, rd); check(rd, 0, "R1 status");
    rdreg(A_C0, rd);   check(rd, 0, "R1 word0");
    check({irq, cmd_valid}, 0, "R1 irq/valid");

    // R2 writes while stopped discarded
    wr(A_C0, 32'hDEAD_0001); idle(2);
    rdreg(A_C0, rd); check(rd, 0, "R2 word while stopped");
    rdreg(A_STAT, rd); check(rd[0], 0, "R2 no request before run");
    wr(A_CTRL, RUN | 32'hFFF); idle(2);
    rdreg(A_STAT, rd); check(rd[0], 1, "R2 request after run");
    rdreg(A_CTRL, rd); check(rd, RUN | 32'hFFF, "R12 ctrl readback");

    // R4 direct writes ignored
    wr(A_C1, 32'h1111_1111); wr(A_C2, 32'h2222_2222); wr(A_C3, 32'h3333_3333); idle(1);
    rdreg(A_C1, rd); check(rd, 0, "R4 word1 direct");
    rdreg(A_C3, rd); check(rd, 0, "R4 word3 direct");

    // R11 abandon partial command
    wr(A_C0, 32'hAAAA_0000); wr(A_C0, 32'hAAAA_0001);
    wr(A_CTRL, 32'hFFF); idle(2); wr(A_CTRL, RUN | 32'hFFF); idle(2);
    v0 = valid_cnt;
    load4(32'h0000_0A00, 32'h0000_0A01, 32'h0000_0A02, 32'h0000_0A03);
    check(valid_cnt - v0, 1, "R5 one valid strobe");
    check(cap_words, {32'h0000_0A03, 32'h0000_0A02, 32'h0000_0A01, 32'h0000_0A00}, "R11 fresh word0");
    rdreg(A_C2, rd); check(rd, 32'h0000_0A02, "R3 word2 readback");
    rdreg(A_C0, rd); check(rd, 32'h0000_0A00, "R3 word0 readback");
    rdreg(A_STAT, rd); check(rd[0], 0, "R5 request low while busy");
    wr(A_C0, 32'h5555_5555); idle(1);
    rdreg(A_C0, rd); check(rd, 32'h0000_0A00, "R5 write while busy dropped");
    check(valid_cnt - v0, 1, "R5 no extra strobe");

    // R6 done for CS0
    done_pulse();
    rdreg(A_STAT, rd); check(rd[8:0], 9'h101, "R6 done cs0 + request");
    wr(A_STAT, 32'hFFF); idle(1);
    rdreg(A_STAT, rd); check(rd, 0, "R8 full clear");

    // R6/R7 CS1 command with page event
    load4(32'h0100_0B00, 32'h1, 32'h2, 32'h3);
    ev_page_done = 1; ev_bad_block = 1; @(negedge clk); ev_page_done = 0; ev_bad_block = 0;
    done_pulse();
    rdreg(A_STAT, rd); check(rd[11:0], 12'h2A1, "R6 R7 cs1 done/page/bbd");
    m_cs = 1;

    // R7 ready levels
    flash_rdy1 = 1; flash_rdy0 = 1; idle(2);
    rdreg(A_STAT, rd); check(rd[12:11], 2'b11, "R7 ready bits");
    flash_rdy1 = 0; flash_rdy0 = 0; idle(2);
    rdreg(A_STAT, rd); check(rd[12:11], 2'b01, "R7 rdy1 follows, rdy0 sticky");
    wr(A_STAT, 32'hFFF); idle(1);

    // R8 set wins over clear
    ev_uncorr = 1; wr(A_STAT, 32'h10); ev_uncorr = 0; idle(1);
    rdreg(A_STAT, rd); check(rd[4], 1, "R8 event beats clear");
    wr(A_STAT, 32'h10); idle(1);
    rdreg(A_STAT, rd); check(rd[4], 0, "R8 w1c bit4");

    // R9 error count
    ev_corr = 1; ev_corr_cnt = 5'd21; @(negedge clk); ev_corr = 0; idle(1);
    rdreg(A_STAT, rd); check(rd[20:16], 21, "R9 count loaded");
    wr(A_STAT, 32'h0007_0008); idle(1);
    rdreg(A_STAT, rd); check({rd[20:16], rd[3]}, {5'd21, 1'b0}, "R9 nonzero field keeps count");
    wr(A_STAT, 32'h0000_0000); idle(1);
    rdreg(A_STAT, rd); check(rd[20:16], 0, "R9 zero field clears");
    wr(A_STAT, 32'hFFF); idle(1);

    // R10 R7 R8 random mix against model
    m_bits = '0; m_cnt = '0;
    void'($urandom(32'h5EED));
    for (int it = 0; it < 60; it++) begin
      logic [31:0] r = $urandom;
      logic [11:0] mask = r[27:16];
      {ev_uncorr, ev_corr, ev_wr_req, ev_rd_req, ev_page_done, ev_bad_block} =
        {r[0], r[1], r[2], r[3], r[4], r[5]};
      ev_corr_cnt = r[10:6];
      @(negedge clk);
      {ev_uncorr, ev_corr, ev_wr_req, ev_rd_req, ev_page_done, ev_bad_block} = '0;
      m_bits |= ev_bits(r[5:0], m_cs);
      if (r[1]) m_cnt = r[10:6];
      if (r[11]) begin
        logic [31:0] cw = {11'b0, r[12] ? 5'd0 : 5'd9, 4'b0, $urandom_range(0, 4095)};
        wr(A_STAT, cw);
        m_bits &= ~cw[11:0];
        if (cw[20:16] == 0) m_cnt = 0;
      end
      wr(A_CTRL, RUN | {20'b0, mask}); idle(1);
      rdreg(A_STAT, rd);
      check(rd[20:0], {m_cnt, 4'b0, m_bits}, "R7 R8 R9 random status");
      check(irq, |(m_bits & ~mask), "R10 irq vs mask");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule